// File: doc/BRIEF.md
# Single-Step Clock Gating Controller

This block sits between a free-running clock and a target processor. It drives a clock-enable toward the target. A mode switch chooses between two behaviours. With the switch off, the target is clocked on every cycle. With the switch on, the enable is withheld and the target is advanced one whole instruction for each press of a step pushbutton.

The length of a step is not a fixed number of cycles. Once a press is accepted, the enable stays high until the target raises its instruction-boundary strobe. The controller then stops the clock again and waits for the button to be let go before it accepts another press. The raw button is synchronized and debounced inside the block.

A lamp output shows when clock pulses are actually delivered. It is stretched, so that a step of a single cycle is still long enough for a person to see. The nominal input clock is 10 MHz, and the default debounce and lamp-hold times are sized for that rate.

Top module: `stepclk_ctrl`

## Requirements
- R1: While reset is held and right after it, the controller is in free-running mode: `tgt_clk_en_o` is 1 and `step_led_o` is 0.
- R2: While the synchronized mode switch is 0, `tgt_clk_en_o` is 1 on every cycle, and button presses have no effect on it.
- R3: When the switch goes to 1 during free running, the enable stays high until the first cycle in which `instr_done_i` is 1, and it is 0 from the next cycle on until a press is accepted.
- R4: Each accepted press keeps `tgt_clk_en_o` high from the cycle after the request up to and including the cycle in which `instr_done_i` is 1, so exactly one instruction is executed, whatever its length in cycles.
- R5: A press that is held for any length of time produces a single request and a single instruction.
- R6: A button level that differs from the debounced level for fewer than `DEBOUNCE_CYCLES` consecutive synchronized cycles is ignored.
- R7: After a step ends, no new step starts until the debounced button has been released and then pressed again.
- R8: A request that arrives while a step is still executing is discarded. It does not lengthen that step and does not start a further one.
- R9: Setting the switch to 0 while in step mode (waiting, running or done) restores a continuous enable one cycle after the synchronized switch reads 0.
- R10: `step_led_o` is 1 in the cycle after every cycle with the enable high, and it stays 1 for exactly `STRETCH_CYCLES` cycles after the last enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, nominally 10 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| step_mode_i | input | 1 | Mode switch, asynchronous: 0 free run, 1 single step |
| step_btn_i | input | 1 | Raw step pushbutton, asynchronous, active high |
| instr_done_i | input | 1 | From the target: 1 in an enabled cycle whose clock edge completes an instruction |
| tgt_clk_en_o | output | 1 | Clock enable for the target |
| step_led_o | output | 1 | Stretched indicator of delivered clock pulses |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES` = 4 and `STRETCH_CYCLES` = 6, keeping `SYNC_STAGES` at its default of 2. At these values a press, its release, a deliberately short glitch and the complete fade of the lamp each take only a few tens of cycles. This makes it practical to place a second press inside a running step and to count the lamp-high cycles exactly.

Inside the bench, a model of the target counts its own enabled cycles and raises the boundary strobe after a chosen instruction length. Lengths of 1, 2, 3, 5 and 30 cycles show that a step is closed by the strobe and not by a fixed cycle count.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

  // Controller states. Free running and draining keep the target clocked;
  // the three stepping states gate it except while one instruction runs.
  typedef enum logic [2:0] {
    ST_FREE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RUN1  = 3'd3,
    ST_DONE  = 3'd4
  } step_state_e;

  function automatic logic state_clocks(step_state_e s);
    return (s == ST_FREE) || (s == ST_DRAIN) || (s == ST_RUN1);
  endfunction

endpackage

// File: rtl/stepclk_sync.sv
module stepclk_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/stepclk_debounce.sv
module stepclk_debounce #(
  parameter int DEBOUNCE_CYCLES = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic level_o,
  output logic press_o
);

  localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [CW-1:0] diff_cnt_q;
  logic          stable_q;
  logic          stable_d1_q;

  // The stable level changes only after the input has disagreed with it
  // for DEBOUNCE_CYCLES consecutive cycles.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diff_cnt_q <= '0;
      stable_q   <= 1'b0;
    end else if (level_i == stable_q) begin
      diff_cnt_q <= '0;
    end else if (diff_cnt_q == LAST) begin
      diff_cnt_q <= '0;
      stable_q   <= level_i;
    end else begin
      diff_cnt_q <= diff_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stable_d1_q <= 1'b0;
    else        stable_d1_q <= stable_q;
  end

  assign level_o = stable_q;
  assign press_o = stable_q & ~stable_d1_q;

endmodule

// File: rtl/stepclk_fsm.sv
module stepclk_fsm
  import stepclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_step_i,
  input  logic req_i,
  input  logic btn_level_i,
  input  logic boundary_i,
  output logic clk_en_o
);

  step_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!mode_step_i) begin
      state_d = ST_FREE;
    end else begin
      unique case (state_q)
        ST_FREE:  state_d = ST_DRAIN;
        ST_DRAIN: if (boundary_i)   state_d = ST_WAIT;
        ST_WAIT:  if (req_i)        state_d = ST_RUN1;
        ST_RUN1:  if (boundary_i)   state_d = ST_DONE;
        ST_DONE:  if (!btn_level_i) state_d = ST_WAIT;
        default:  state_d = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_FREE;
    else        state_q <= state_d;
  end

  assign clk_en_o = state_clocks(state_q);

endmodule

// File: rtl/stepclk_stretch.sv
module stepclk_stretch #(
  parameter int STRETCH_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic lamp_o
);

  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [SW-1:0] HOLD = SW'(STRETCH_CYCLES);

  logic [SW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              hold_q <= '0;
    else if (pulse_i)        hold_q <= HOLD;
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign lamp_o = (hold_q != '0);

endmodule

// File: rtl/stepclk_ctrl.sv
module stepclk_ctrl #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 200_000,
  parameter int STRETCH_CYCLES  = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_mode_i,
  input  logic step_btn_i,
  input  logic instr_done_i,
  output logic tgt_clk_en_o,
  output logic step_led_o
);

  logic [1:0] raw_in;
  logic [1:0] sync_in;
  logic       mode_sync;
  logic       btn_sync;
  logic       btn_level;
  logic       btn_req;

  assign raw_in = {step_mode_i, step_btn_i};
  assign {mode_sync, btn_sync} = sync_in;

  stepclk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .sync_o (sync_in)
  );

  stepclk_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(btn_sync),
    .level_o(btn_level),
    .press_o(btn_req)
  );

  stepclk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_step_i(mode_sync),
    .req_i      (btn_req),
    .btn_level_i(btn_level),
    .boundary_i (instr_done_i),
    .clk_en_o   (tgt_clk_en_o)
  );

  stepclk_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_lamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .pulse_i(tgt_clk_en_o),
    .lamp_o (step_led_o)
  );

endmodule

// File: rtl/stepclk_ctrl_chk.sv
module stepclk_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic boundary,
  input logic led,
  input logic req,
  input logic mode_s
);

  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> $past(boundary)); // R4

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(req) || !$past(mode_s))); // R7

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R5

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> clk_en); // R2

  AST_LAMP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> led); // R10

endmodule

bind stepclk_ctrl stepclk_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_en  (tgt_clk_en_o),
  .boundary(instr_done_i),
  .led     (step_led_o),
  .req     (btn_req),
  .mode_s  (mode_sync)
);

// File: tb/tb_stepclk_ctrl.sv
module tb_stepclk_ctrl;

  localparam int CLK_PERIOD = 100;
  localparam int DEB        = 4;
  localparam int STR        = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic btn = 1'b0;
  logic en;
  logic led;
  logic boundary;

  int ilen = 5;
  int icnt = 0;
  int delivered = 0;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepclk_ctrl #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB), .STRETCH_CYCLES(STR)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_mode_i (mode),
    .step_btn_i  (btn),
    .instr_done_i(boundary),
    .tgt_clk_en_o(en),
    .step_led_o  (led)
  );

  // Target model: an instruction lasts ilen enabled cycles.
  assign boundary = en && (icnt == ilen - 1);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) icnt <= 0;
    else if (en) begin
      icnt <= boundary ? 0 : icnt + 1;
      delivered <= delivered + 1;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press();
    btn = 1'b1;
    cyc(DEB + 6);
    btn = 1'b0;
    cyc(DEB + 10 + ilen);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 en in reset", int'(en), 1);
    chk("R1 led in reset", int'(led), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en after reset", int'(en), 1);
  endtask

  task automatic t_free();
    int base;
    base = delivered;
    btn = 1'b1;
    cyc(15);
    btn = 1'b0;
    cyc(15);
    chk("R2 continuous enable with presses", delivered - base, 30);
    chk("R2 en level", int'(en), 1);
  endtask

  task automatic t_enter();
    int base;
    ilen = 5;
    mode = 1'b1;
    cyc(20);
    chk("R3 gated after boundary", int'(en), 0);
    chk("R3 stopped at instruction start", icnt, 0);
    base = delivered;
    cyc(10);
    chk("R3 no pulses while waiting", delivered - base, 0);
  endtask

  task automatic t_steps();
    int lens[3] = '{1, 3, 5};
    foreach (lens[k]) begin
      int base;
      ilen = lens[k];
      base = delivered;
      press();
      chk("R4 one instruction per press", delivered - base, lens[k]);
      chk("R4 gated after step", int'(en), 0);
    end
  endtask

  task automatic t_hold();
    int base;
    ilen = 3;
    base = delivered;
    btn = 1'b1;
    cyc(60);
    chk("R5 held button gives one step", delivered - base, 3);
    chk("R5 gated while held", int'(en), 0);
    btn = 1'b0;
    cyc(15);
    chk("R5 release adds nothing", delivered - base, 3);
  endtask

  task automatic t_glitch();
    int base;
    base = delivered;
    btn = 1'b1;
    cyc(DEB - 2);
    btn = 1'b0;
    cyc(30);
    chk("R6 short glitch ignored", delivered - base, 0);
  endtask

  task automatic t_rearm();
    int base;
    ilen = 2;
    base = delivered;
    btn = 1'b1;
    cyc(40);
    chk("R7 held after step", delivered - base, 2);
    btn = 1'b0;
    cyc(20);
    chk("R7 release alone no step", delivered - base, 2);
    press();
    chk("R7 new press steps again", delivered - base, 4);
  endtask

  task automatic t_ignore();
    int base;
    ilen = 30;
    base = delivered;
    btn = 1'b1;
    cyc(DEB + 6);
    btn = 1'b0;
    cyc(DEB + 4);
    btn = 1'b1;
    cyc(DEB + 6);
    btn = 1'b0;
    cyc(60);
    chk("R8 request during run discarded", delivered - base, 30);
    chk("R8 gated after run", int'(en), 0);
  endtask

  task automatic t_led();
    int on_cnt = 0;
    ilen = 1;
    cyc(STR + 4);
    chk("R10 lamp dark while waiting", int'(led), 0);
    btn = 1'b1;
    for (int i = 0; i < DEB + 6; i++) begin
      @(negedge clk);
      if (led) on_cnt++;
    end
    btn = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (led) on_cnt++;
    end
    chk("R10 lamp stretch length", on_cnt, STR);
  endtask

  task automatic t_exit();
    int base;
    mode = 1'b0;
    cyc(4);
    chk("R9 free run restored", int'(en), 1);
    base = delivered;
    cyc(10);
    chk("R9 continuous after exit", delivered - base, 10);
    ilen = 40;
    mode = 1'b1;
    cyc(60);
    btn = 1'b1;
    cyc(DEB + 8);
    mode = 1'b0;
    cyc(4);
    chk("R9 exit from running step", int'(en), 1);
    btn = 1'b0;
  endtask

  initial begin
    t_reset();
    t_free();
    t_enter();
    t_steps();
    t_hold();
    t_glitch();
    t_rearm();
    t_ignore();
    t_led();
    t_exit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100_000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule